// File: doc/BRIEF.md
# CEC Bit-Timing Transmitter

This block sends one message on a single-wire, open-drain consumer-electronics control bus. It never drives the wire high. It only asserts an output enable that pulls the wire low, and it reads the wire back through a separate input. All timing comes from a tick input of about 32768 Hz, so every duration below is a count of ticks.

A transmission runs in three steps:
- The block first waits until the wire has stayed released for a selectable signal-free interval.
- It then sends a start symbol followed by the bytes. Each byte goes out most significant bit first and is followed by an end-of-message bit and an acknowledge slot.
- While it has the wire released it checks for another initiator holding the wire low. In each acknowledge slot it samples the follower's answer.

The block ends with a single completion pulse and a result code: accepted, not acknowledged, or arbitration lost. Bytes come from a source that holds the next byte and its last flag stable until the block pulses `data_take_o`. Retry policy, message buffering and receive decoding belong to surrounding logic.

Top module: `cec_bit_tx`

## Requirements
- R1: After reset `line_oe_o`, `busy_o`, `done_o` and `data_take_o` are 0 and `result_o` is 0 (no result yet).
- R2: `start_i` is accepted only while idle. The wire must then stay high for a number of consecutive ticks set by `free_sel_i`: 0 or 3 selects 557 ticks (about 17 ms), 1 selects 157 ticks (two bit periods) and 2 selects 315 ticks (four bit periods). With a tick on every clock, `line_oe_o` rises in the cycle after the limit-th clock edge that follows acceptance.
- R3: Any cycle in which `line_i` is low during the wait restarts the signal-free count from zero.
- R4: The start symbol drives the wire low for 121 ticks and then releases it for 26 ticks.
- R5: Bits are timed as follows:
  - Each byte is sent most significant bit first.
  - A 1 is 20 ticks low and 59 ticks released.
  - A 0 is 49 ticks low and 29 ticks released.
  - Each byte is followed by an end-of-message bit, which is 1 only for the last byte, and then by an acknowledge slot timed as a 1.
- R6: `data_i` and `last_i` are captured at two points, each followed one cycle later by a one-cycle `data_take_o` pulse:
  - when `start_i` is accepted;
  - 2 ticks before the end of each acknowledge slot that is followed by another byte.
- R7: In every released phase of the start, data and end-of-message symbols, the wire is sampled 3 ticks after release. If it is low, the block stops driving at once, pulses `done_o` with result 3 (arbitration lost) and sends nothing more.
- R8: In the acknowledge slot the wire is sampled 15 ticks after release:
  - A directed message (low nibble of the first byte not 0xF) counts as acknowledged when the sample is low.
  - A broadcast (low nibble 0xF) counts as accepted when the sample is high.
  - Otherwise the block pulses `done_o` with result 2 (not acknowledged) and stops.
- R9: When the acknowledge slot of the last byte completes, the block pulses `done_o` for one cycle with result 1 and `busy_o` falls. `result_o` holds its value until the next completion.
- R10: Timers advance only on clocks with `tick_i` high. A clock without a tick changes neither the wire drive nor the symbol sequence.
- R11: `start_i` has no effect while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase strobe, one clock wide, about 32768 Hz |
| start_i | input | 1 | Begin a transmission (taken only when idle) |
| free_sel_i | input | 2 | Signal-free interval select |
| data_i | input | 8 | Byte to send |
| last_i | input | 1 | Marks `data_i` as the final byte of the message |
| data_take_o | output | 1 | Pulse: `data_i`/`last_i` were captured in the previous cycle |
| line_i | input | 1 | Wire level read back (1 = released) |
| line_oe_o | output | 1 | 1 pulls the wire low |
| busy_o | output | 1 | Transmission in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 1 accepted, 2 not acknowledged, 3 arbitration lost |

## Verification
Most internal faults show up directly on `line_oe_o`. A wrong symbol counter, bit index or phase state stretches or shortens a low or released run, and the error is visible within one symbol time (at most about 150 ticks). A wrong byte latch or end-of-message flag shows up as a mismatched pulse width in the next byte. A stuck signal-free counter moves the first falling edge by hundreds of ticks. Faults in the arbitration or acknowledge sampling appear as a wrong `result_o`, or as a wrong number of driven pulses, at the sample tick of the affected slot.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FREE = 2'd1,
        ST_LOW  = 2'd2,
        ST_HIGH = 2'd3
    } tx_state_e;

    typedef enum logic [1:0] {
        SYM_START = 2'd0,
        SYM_DATA  = 2'd1,
        SYM_EOM   = 2'd2,
        SYM_ACK   = 2'd3
    } tx_sym_e;

    typedef enum logic [1:0] {
        RES_NONE = 2'd0,
        RES_OK   = 2'd1,
        RES_NACK = 2'd2,
        RES_ARB  = 2'd3
    } tx_result_e;

    localparam logic [1:0] FREE_SEL_2BIT = 2'd1;
    localparam logic [1:0] FREE_SEL_4BIT = 2'd2;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cec_tx_sym_len.sv
module cec_tx_sym_len
    import cec_tx_pkg::*;
#(
    parameter int unsigned T_START_LO = 121,
    parameter int unsigned T_START_HI = 26,
    parameter int unsigned T_ONE_LO   = 20,
    parameter int unsigned T_ONE_HI   = 59,
    parameter int unsigned T_ZERO_LO  = 49,
    parameter int unsigned T_ZERO_HI  = 29,
    parameter int unsigned LEN_W      = 8
) (
    input  tx_sym_e          sym_i,
    input  logic             bit_i,
    output logic [LEN_W-1:0] low_len_o,
    output logic [LEN_W-1:0] high_len_o
);

    // Low and released durations of the symbol currently on the wire.
    always_comb begin
        case (sym_i)
            SYM_START: begin
                low_len_o  = LEN_W'(T_START_LO);
                high_len_o = LEN_W'(T_START_HI);
            end
            SYM_ACK: begin
                // The initiator always offers a 1 in the acknowledge slot.
                low_len_o  = LEN_W'(T_ONE_LO);
                high_len_o = LEN_W'(T_ONE_HI);
            end
            default: begin
                low_len_o  = bit_i ? LEN_W'(T_ONE_LO) : LEN_W'(T_ZERO_LO);
                high_len_o = bit_i ? LEN_W'(T_ONE_HI) : LEN_W'(T_ZERO_HI);
            end
        endcase
    end

endmodule

// File: rtl/cec_tx_free_wait.sv
module cec_tx_free_wait
    import cec_tx_pkg::*;
#(
    parameter int unsigned T_FREE_LONG = 557,
    parameter int unsigned T_FREE_2BIT = 157,
    parameter int unsigned T_FREE_4BIT = 315
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       en_i,
    input  logic       tick_i,
    input  logic       line_i,
    input  logic [1:0] sel_i,
    output logic       expired_o
);

    localparam int unsigned FREE_MAX = max2(T_FREE_LONG, max2(T_FREE_2BIT, T_FREE_4BIT));
    localparam int unsigned FW       = $clog2(FREE_MAX + 1);

    logic [FW-1:0] limit;
    logic [FW-1:0] cnt_d, cnt_q;

    always_comb begin
        case (sel_i)
            FREE_SEL_2BIT: limit = FW'(T_FREE_2BIT);
            FREE_SEL_4BIT: limit = FW'(T_FREE_4BIT);
            default:       limit = FW'(T_FREE_LONG);
        endcase
    end

    // Counts consecutive ticks of a released wire; any low level restarts it.
    always_comb begin
        cnt_d     = cnt_q;
        expired_o = 1'b0;
        if (!en_i || !line_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            if (cnt_q + FW'(1) == limit) begin
                expired_o = 1'b1;
                cnt_d     = '0;
            end else begin
                cnt_d = cnt_q + FW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/cec_bit_tx.sv
module cec_bit_tx
    import cec_tx_pkg::*;
#(
    parameter int unsigned BYTE_W       = 8,
    parameter int unsigned T_START_LO   = 121,
    parameter int unsigned T_START_HI   = 26,
    parameter int unsigned T_ONE_LO     = 20,
    parameter int unsigned T_ONE_HI     = 59,
    parameter int unsigned T_ZERO_LO    = 49,
    parameter int unsigned T_ZERO_HI    = 29,
    parameter int unsigned T_CHECK      = 3,
    parameter int unsigned T_ACK_SAMPLE = 15,
    parameter int unsigned T_PREP       = 2,
    parameter int unsigned T_FREE_LONG  = 557,
    parameter int unsigned T_FREE_2BIT  = 157,
    parameter int unsigned T_FREE_4BIT  = 315
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              start_i,
    input  logic [1:0]        free_sel_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              last_i,
    output logic              data_take_o,
    input  logic              line_i,
    output logic              line_oe_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        result_o
);

    localparam int unsigned LEN_MAX = max2(max2(T_START_LO, T_START_HI),
                                           max2(max2(T_ONE_LO, T_ONE_HI),
                                                max2(T_ZERO_LO, T_ZERO_HI)));
    localparam int unsigned SW      = $clog2(LEN_MAX + 1);
    localparam int unsigned BIT_W   = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

    typedef struct packed {
        tx_state_e         st;
        tx_sym_e           sym;
        logic [BIT_W-1:0]  bit_idx;
        logic [BYTE_W-1:0] shreg;
        logic              last;    // current byte is the final one
        logic              more;    // next byte already fetched in this ACK slot
        logic              bcast;   // destination nibble of the header is all ones
        logic [1:0]        sel;
        logic [SW-1:0]     cnt;
        logic              take;
        logic              done;
        tx_result_e        result;
    } tx_regs_t;

    tx_regs_t      s_d, s_q;
    logic          cur_bit;
    logic [SW-1:0] low_len, high_len;
    logic [SW-1:0] cnt_inc;
    logic          free_done;

    assign cur_bit = (s_q.sym == SYM_EOM) ? s_q.last : s_q.shreg[s_q.bit_idx];

    cec_tx_sym_len #(
        .T_START_LO (T_START_LO),
        .T_START_HI (T_START_HI),
        .T_ONE_LO   (T_ONE_LO),
        .T_ONE_HI   (T_ONE_HI),
        .T_ZERO_LO  (T_ZERO_LO),
        .T_ZERO_HI  (T_ZERO_HI),
        .LEN_W      (SW)
    ) u_len (
        .sym_i      (s_q.sym),
        .bit_i      (cur_bit),
        .low_len_o  (low_len),
        .high_len_o (high_len)
    );

    cec_tx_free_wait #(
        .T_FREE_LONG (T_FREE_LONG),
        .T_FREE_2BIT (T_FREE_2BIT),
        .T_FREE_4BIT (T_FREE_4BIT)
    ) u_free (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (s_q.st == ST_FREE),
        .tick_i    (tick_i),
        .line_i    (line_i),
        .sel_i     (s_q.sel),
        .expired_o (free_done)
    );

    always_comb begin
        s_d      = s_q;
        s_d.take = 1'b0;
        s_d.done = 1'b0;
        cnt_inc  = s_q.cnt + SW'(1);

        case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.shreg = data_i;
                    s_d.last  = last_i;
                    s_d.more  = 1'b0;
                    s_d.bcast = (data_i[3:0] == 4'hF);
                    s_d.sel   = free_sel_i;
                    s_d.cnt   = '0;
                    s_d.take  = 1'b1;
                    s_d.st    = ST_FREE;
                end
            end

            ST_FREE: begin
                if (free_done) begin
                    s_d.st  = ST_LOW;
                    s_d.sym = SYM_START;
                    s_d.cnt = '0;
                end
            end

            ST_LOW: begin
                if (tick_i) begin
                    if (cnt_inc == low_len) begin
                        s_d.st  = ST_HIGH;
                        s_d.cnt = '0;
                    end else begin
                        s_d.cnt = cnt_inc;
                    end
                end
            end

            ST_HIGH: begin
                if (tick_i) begin
                    s_d.cnt = cnt_inc;
                    if (s_q.sym != SYM_ACK && cnt_inc == SW'(T_CHECK) && !line_i) begin
                        // Another initiator holds the wire: give it up now.
                        s_d.st     = ST_IDLE;
                        s_d.done   = 1'b1;
                        s_d.result = RES_ARB;
                        s_d.cnt    = '0;
                    end else if (s_q.sym == SYM_ACK && cnt_inc == SW'(T_ACK_SAMPLE) &&
                                 (s_q.bcast ? !line_i : line_i)) begin
                        s_d.st     = ST_IDLE;
                        s_d.done   = 1'b1;
                        s_d.result = RES_NACK;
                        s_d.cnt    = '0;
                    end else begin
                        if (s_q.sym == SYM_ACK && !s_q.last &&
                            cnt_inc == high_len - SW'(T_PREP)) begin
                            s_d.shreg = data_i;
                            s_d.last  = last_i;
                            s_d.more  = 1'b1;
                            s_d.take  = 1'b1;
                        end
                        if (cnt_inc == high_len) begin
                            s_d.cnt = '0;
                            s_d.st  = ST_LOW;
                            case (s_q.sym)
                                SYM_START: begin
                                    s_d.sym     = SYM_DATA;
                                    s_d.bit_idx = BIT_W'(BYTE_W - 1);
                                end
                                SYM_DATA: begin
                                    if (s_q.bit_idx == '0) begin
                                        s_d.sym = SYM_EOM;
                                    end else begin
                                        s_d.bit_idx = s_q.bit_idx - BIT_W'(1);
                                    end
                                end
                                SYM_EOM: begin
                                    s_d.sym = SYM_ACK;
                                end
                                default: begin
                                    if (s_q.more) begin
                                        s_d.more    = 1'b0;
                                        s_d.sym     = SYM_DATA;
                                        s_d.bit_idx = BIT_W'(BYTE_W - 1);
                                    end else begin
                                        s_d.st     = ST_IDLE;
                                        s_d.done   = 1'b1;
                                        s_d.result = RES_OK;
                                    end
                                end
                            endcase
                        end
                    end
                end
            end

            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign line_oe_o   = (s_q.st == ST_LOW);
    assign busy_o      = (s_q.st != ST_IDLE);
    assign done_o      = s_q.done;
    assign data_take_o = s_q.take;
    assign result_o    = s_q.result;

endmodule

// File: rtl/cec_bit_tx_chk.sv
module cec_bit_tx_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       tick_i,
    input logic       line_oe_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       data_take_o,
    input logic [1:0] result_o
);

    AST_DRIVE_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        line_oe_o |-> busy_o); // R7

    AST_DONE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && !line_oe_o)); // R9

    AST_DONE_HAS_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (result_o != 2'd0)); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R9

    AST_TAKE_WHILE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        data_take_o |-> (busy_o && !line_oe_o)); // R6

    AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !tick_i) |=> (busy_o && $stable(line_oe_o))); // R10

endmodule

bind cec_bit_tx cec_bit_tx_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .line_oe_o   (line_oe_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .data_take_o (data_take_o),
    .result_o    (result_o)
);

// File: tb/cec_bit_tx_bench.sv
module cec_bit_tx_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       start = 1'b0;
    logic [1:0] sel = 2'd0;
    logic [7:0] data = 8'h00;
    logic       last_b = 1'b0;
    logic       pull = 1'b0;
    logic       ext_pull = 1'b0;
    logic       take, oe, busy, done;
    logic [1:0] result;
    logic       line;

    assign line = !(oe | pull | ext_pull);

    always #(CLK_PERIOD / 2) clk = ~clk;

    cec_bit_tx u_cec_bit_tx (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tick_i      (tick),
        .start_i     (start),
        .free_sel_i  (sel),
        .data_i      (data),
        .last_i      (last_b),
        .data_take_o (take),
        .line_i      (line),
        .line_oe_o   (oe),
        .busy_o      (busy),
        .done_o      (done),
        .result_o    (result)
    );

    int n_chk = 0;
    int n_err = 0;

    // Wire monitor, follower/competitor model and byte source.
    int         pulse_no, lo_run, hi_run, pull_cnt, take_cnt, feed_idx;
    int         msg_n, ack_en, arb_a, arb_b;
    int         lo_w [64];
    int         hi_w [64];
    logic [7:0] msg [4];
    logic       oe_prev = 1'b0;

    always @(negedge clk) begin
        if (pull_cnt > 0) pull_cnt--;
        if (oe && !oe_prev) begin
            if (pulse_no > 0 && pulse_no <= 64) hi_w[pulse_no-1] = hi_run;
            pulse_no++;
            lo_run = 0;
            if ((ack_en != 0 && pulse_no > 1 && pulse_no % 10 == 1) ||
                pulse_no == arb_a || pulse_no == arb_b)
                pull_cnt = 49;
        end
        if (!oe && oe_prev) begin
            if (pulse_no > 0 && pulse_no <= 64) lo_w[pulse_no-1] = lo_run;
            hi_run = 0;
        end
        if (oe) lo_run++;
        else    hi_run++;
        oe_prev = oe;
        pull = (pull_cnt > 0);
        if (take) begin
            take_cnt++;
            feed_idx++;
            if (feed_idx < msg_n && feed_idx < 4) data = msg[feed_idx];
            last_b = (feed_idx == msg_n - 1);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_bit(input int p, input int n);
        int q = (p - 1) % 10;
        int b = (p - 1) / 10;
        if (b > 3) return 1;
        if (q < 8) return int'(msg[b][7-q]);
        if (q == 8) return (b == n - 1) ? 1 : 0;
        return 1;
    endfunction

    // Compare recorded pulse widths with the symbol timing rules.
    task automatic check_widths(input int n, input string tag);
        int bad_act = 0;
        int bad_exp = 0;
        int mism = 0;
        if (pulse_no >= 2) begin
            chk(lo_w[0] == 121, {"R4 start low ", tag}, lo_w[0], 121);
            chk(hi_w[0] == 26, {"R4 start high ", tag}, hi_w[0], 26);
        end
        for (int p = 1; p < pulse_no && p < 64; p++) begin
            int bv = exp_bit(p, n);
            int el = (bv != 0) ? 20 : 49;
            int eh = (bv != 0) ? 59 : 29;
            if (lo_w[p] != el && mism == 0) begin bad_act = lo_w[p]; bad_exp = el; end
            if (lo_w[p] != el) mism++;
            if (p < pulse_no - 1) begin
                if (hi_w[p] != eh && mism == 0) begin bad_act = hi_w[p]; bad_exp = eh; end
                if (hi_w[p] != eh) mism++;
            end
        end
        chk(mism == 0, {"R5 bit widths ", tag}, bad_act, bad_exp);
    endtask

    task automatic run_msg(input int n, input int s, input int ack, input int a,
                           input int b, input int gate, input int pull_at,
                           input bit inject, output int res, output int wait_c);
        int k = 0;
        msg_n = n; ack_en = ack; arb_a = a; arb_b = b;
        pulse_no = 0; lo_run = 0; hi_run = 0; take_cnt = 0; feed_idx = 0; pull_cnt = 0;
        for (int i = 0; i < 64; i++) begin lo_w[i] = 0; hi_w[i] = 0; end
        data = msg[0];
        last_b = (n == 1);
        @(negedge clk);
        start = 1'b1;
        sel = 2'(s);
        if (gate > 0) tick = 1'b0;
        wait_c = 0;
        while (1) begin
            @(negedge clk);
            wait_c++;
            if (wait_c == 1) start = 1'b0;
            if (gate > 0 && wait_c == gate) tick = 1'b1;
            if (pull_at > 0 && wait_c == pull_at) ext_pull = 1'b1;
            if (pull_at > 0 && wait_c == pull_at + 10) ext_pull = 1'b0;
            if (oe || wait_c > 5000) break;
        end
        while (!done && k < 40000) begin
            @(negedge clk);
            k++;
            start = (inject && k == 300);
        end
        start = 1'b0;
        res = int'(result);
    endtask

    task automatic t_reset();
        chk(oe == 1'b0, "R1 oe after reset", int'(oe), 0);
        chk(busy == 1'b0 && done == 1'b0 && take == 1'b0, "R1 busy/done/take after reset",
            int'({busy, done, take}), 0);
        chk(result == 2'd0, "R1 result after reset", int'(result), 0);
    endtask

    task automatic t_directed();
        int res, w, idle_busy;
        msg[0] = 8'h40; msg[1] = 8'h82; msg[2] = 8'h5A;
        run_msg(3, 0, 1, -1, -1, 0, 0, 1'b1, res, w);
        chk(w == 558, "R2 long signal-free wait", w, 558);
        chk(res == 1, "R9 directed result ok", res, 1);
        chk(pulse_no == 31, "R5 directed pulse count", pulse_no, 31);
        chk(take_cnt == 3, "R6 R11 byte fetches", take_cnt, 3);
        check_widths(3, "directed");
        idle_busy = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (busy || oe) idle_busy++;
        end
        chk(idle_busy == 0, "R11 stray start while busy did not restart", idle_busy, 0);
    endtask

    task automatic t_bcast_ok();
        int res, w;
        msg[0] = 8'h4F;
        run_msg(1, 1, 0, -1, -1, 0, 0, 1'b0, res, w);
        chk(w == 158, "R2 two-bit signal-free wait", w, 158);
        chk(res == 1, "R8 broadcast with high ack accepted", res, 1);
        chk(pulse_no == 11, "R5 single byte pulse count", pulse_no, 11);
        check_widths(1, "broadcast");
    endtask

    task automatic t_bcast_reject();
        int res, w;
        msg[0] = 8'h4F; msg[1] = 8'h36;
        run_msg(2, 3, 1, -1, -1, 0, 0, 1'b0, res, w);
        chk(w == 558, "R2 select 3 uses long wait", w, 558);
        chk(res == 2, "R8 broadcast with low ack rejected", res, 2);
        chk(pulse_no == 11, "R8 stops after first ack slot", pulse_no, 11);
        chk(take_cnt == 1, "R6 no fetch after reject", take_cnt, 1);
    endtask

    task automatic t_nack();
        int res, w;
        msg[0] = 8'h45; msg[1] = 8'h11;
        run_msg(2, 2, 0, -1, -1, 0, 0, 1'b0, res, w);
        chk(w == 316, "R2 four-bit signal-free wait", w, 316);
        chk(res == 2, "R8 directed without ack", res, 2);
        chk(pulse_no == 11, "R8 directed nack pulse count", pulse_no, 11);
    endtask

    task automatic t_arb();
        int res, w, late;
        msg[0] = 8'h40; msg[1] = 8'h00;
        run_msg(2, 1, 1, 2, 3, 0, 0, 1'b0, res, w);
        chk(res == 3, "R7 arbitration lost result", res, 3);
        chk(pulse_no == 3, "R7 no drive after loss", pulse_no, 3);
        check_widths(2, "arbitration");
        late = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (oe || busy) late++;
        end
        chk(late == 0, "R7 stays released after loss", late, 0);
    endtask

    task automatic t_restart();
        int res, w;
        msg[0] = 8'h4F;
        run_msg(1, 1, 0, -1, -1, 0, 50, 1'b0, res, w);
        chk(w == 217, "R3 low wire restarts signal-free count", w, 217);
        chk(res == 1, "R3 message completes after restart", res, 1);
    endtask

    task automatic t_tick_gate();
        int res, w;
        msg[0] = 8'h4F;
        run_msg(1, 1, 0, -1, -1, 40, 0, 1'b0, res, w);
        chk(w == 197, "R10 wait holds without ticks", w, 197);
        chk(res == 1, "R10 message completes", res, 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_directed();
        t_bcast_ok();
        t_bcast_reject();
        t_nack();
        t_arb();
        t_restart();
        t_tick_gate();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule